// File: doc/BRIEF.md
# Slave-Side Cell Output Queue

This block buffers whole ATM-style cells and hands them to a downstream device over a 16-bit word bus on which it is the slave. An upstream producer writes cells one word at a time into a queue that holds four cells. The downstream device drives a read-enable input whenever it can take data. The block starts a cell only when a complete cell is stored, and it marks each transferred word with a cell-available flag.

The cell-available flag is meant to drive the write-enable of a peer that is also a slave. By default it stays active through the last word of a cell. A mode input moves its deassertion to the point four words before the end, and a second mode input inverts it so that it can feed an active-low enable without glue. The first word of every cell carries a start-of-cell mark, and every word leaves with odd parity. If read-enable drops in the middle of a cell, the transfer stalls and later resumes at the same word.

A cell that starts arriving while all four slots hold complete cells is discarded as a whole. Each of its words raises a drop flag.

Top module: `cell_out_slave`

## Requirements
- R1: After reset, cav_o equals cfg_cav_inv_i (inactive), soc_o is 0, wr_full_o is 0 and wr_drop_o is 0.
- R2: No word is sent while fewer than one complete cell (CELL_WORDS words, default 27) is stored, even with rd_en_i high.
- R3: A word appears on dat_o in the cycle after an edge at which rd_en_i was sampled high and a word was eligible. soc_o is 1 on the first word of each cell and 0 otherwise.
- R4: While rd_en_i is low, no word is transferred and cav_o is inactive. A paused cell resumes at the next unsent word.
- R5: With both mode inputs low, cav_o is 1 exactly in the cycles that carry a word of a cell, including the last word.
- R6: With cfg_early_off_i high, cav_o is inactive on the final four words of each cell and active on the others.
- R7: With cfg_cav_inv_i high, cav_o is the complement of its non-inverted value.
- R8: par_o makes the 17 bits {dat_o, par_o} have odd parity on every transferred word.
- R9: wr_full_o is 1 while four complete cells are stored. A cell whose first word arrives in that state is dropped in full, and wr_drop_o is 1 in the cycle after each of its words.
- R10: Cells leave in the order written with their words in order. With rd_en_i held high, the next stored cell follows the previous one without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one word of the incoming cell |
| wr_data_i | input | 16 | Incoming word |
| wr_full_o | output | 1 | Four complete cells stored |
| wr_drop_o | output | 1 | The previous write was discarded |
| rd_en_i | input | 1 | Downstream read-enable |
| cfg_early_off_i | input | 1 | Deassert cav_o four words before cell end |
| cfg_cav_inv_i | input | 1 | Invert cav_o |
| dat_o | output | 16 | Outgoing word |
| soc_o | output | 1 | First word of a cell |
| par_o | output | 1 | Odd parity bit over dat_o |
| cav_o | output | 1 | Cell-available flag |

## Verification
The assertions assume that the producer writes complete cells of CELL_WORDS words. Word counting inside the block depends on this, and an incomplete cell would shift every later cell boundary. The stimulus only issues whole cells: a cell's words may be spread out by idle cycles, but a cell is never abandoned. The mode inputs change only between phases, while no cell is in flight. The alignment of the early deassertion therefore never depends on a mode switch in mid-cell.

// File: rtl/cof_pkg.sv
package cof_pkg;
  localparam int unsigned COF_DW         = 16;
  localparam int unsigned COF_CELL_WORDS = 27;
  localparam int unsigned COF_DEPTH      = 4;
  localparam int unsigned COF_EARLY      = 4;
endpackage

// File: rtl/cof_store.sv
module cof_store #(
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 27,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned IDX_W  = $clog2(CW),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             wr_full_o,
  output logic             wr_drop_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             free_i,
  output logic             avail_o,
  output logic [DW-1:0]    rd_word_o
);
  logic [DW-1:0]     mem [DEPTH][CW];
  logic [SLOT_W-1:0] wr_slot_q, rd_slot_q;
  logic [IDX_W-1:0]  wr_idx_q;
  logic              dropping_q, drop_q;
  logic [CNT_W-1:0]  committed_q;
  logic              accept, commit, first_word, has_room;

  assign first_word = (wr_idx_q == '0);
  assign has_room   = (committed_q < CNT_W'(DEPTH));
  assign accept     = wr_en_i && (first_word ? has_room : !dropping_q);
  assign commit     = accept && (wr_idx_q == IDX_W'(CW - 1));

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(DEPTH - 1)) ? '0 : s + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_slot_q   <= '0;
      rd_slot_q   <= '0;
      wr_idx_q    <= '0;
      dropping_q  <= 1'b0;
      drop_q      <= 1'b0;
      committed_q <= '0;
    end else begin
      drop_q <= wr_en_i && !accept;
      if (wr_en_i) begin
        if (first_word) dropping_q <= !has_room;
        wr_idx_q <= (wr_idx_q == IDX_W'(CW - 1)) ? '0 : wr_idx_q + 1'b1;
      end
      if (commit) wr_slot_q <= next_slot(wr_slot_q);
      if (free_i) rd_slot_q <= next_slot(rd_slot_q);
      committed_q <= committed_q + CNT_W'(commit) - CNT_W'(free_i);
    end
  end

  // one write port per slot row
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i) begin
      if (accept && wr_slot_q == SLOT_W'(g)) mem[g][wr_idx_q] <= wr_data_i;
    end
  end

  assign rd_word_o = mem[rd_slot_q][rd_idx_i];
  assign avail_o   = (committed_q != '0);
  assign wr_full_o = (committed_q == CNT_W'(DEPTH));
  assign wr_drop_o = drop_q;

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    committed_q <= CNT_W'(DEPTH));
  assert_drop_when_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && first_word && wr_full_o) |=> wr_drop_o);
endmodule

// File: rtl/cof_reader.sv
module cof_reader #(
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 27,
  parameter int unsigned EARLY = 4,
  localparam int unsigned IDX_W = $clog2(CW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic             avail_i,
  input  logic [DW-1:0]    word_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             free_o,
  output logic [DW-1:0]    dat_o,
  output logic             soc_o,
  output logic             par_o,
  output logic             vld_o,
  output logic             tail_o
);
  logic [IDX_W-1:0] rd_idx_q;
  logic             go, last;

  assign last   = (rd_idx_q == IDX_W'(CW - 1));
  assign go     = rd_en_i && ((rd_idx_q != '0) || avail_i);
  assign free_o = go && last;
  assign rd_idx_o = rd_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_q <= '0;
      dat_o    <= '0;
      soc_o    <= 1'b0;
      par_o    <= 1'b1;
      vld_o    <= 1'b0;
      tail_o   <= 1'b0;
    end else begin
      vld_o  <= go;
      soc_o  <= go && (rd_idx_q == '0);
      tail_o <= go && (rd_idx_q >= IDX_W'(CW - EARLY));
      if (go) begin
        dat_o    <= word_i;
        par_o    <= ~^word_i;
        rd_idx_q <= last ? '0 : rd_idx_q + 1'b1;
      end
    end
  end

  assert_pause_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!vld_o && $stable(rd_idx_q)));
  assert_start_needs_cell_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_idx_q == '0 && !avail_i) |=> !vld_o);
endmodule

// File: rtl/cell_out_slave.sv
module cell_out_slave
  import cof_pkg::*;
#(
  parameter int unsigned DW    = COF_DW,
  parameter int unsigned CW    = COF_CELL_WORDS,
  parameter int unsigned DEPTH = COF_DEPTH,
  parameter int unsigned EARLY = COF_EARLY
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_full_o,
  output logic          wr_drop_o,
  input  logic          rd_en_i,
  input  logic          cfg_early_off_i,
  input  logic          cfg_cav_inv_i,
  output logic [DW-1:0] dat_o,
  output logic          soc_o,
  output logic          par_o,
  output logic          cav_o
);
  localparam int unsigned IDX_W = $clog2(CW);

  logic [IDX_W-1:0] rd_idx;
  logic             free, avail, vld, tail;
  logic [DW-1:0]    rd_word;

  cof_store #(.DW(DW), .CW(CW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .wr_full_o, .wr_drop_o,
    .rd_idx_i(rd_idx), .free_i(free), .avail_o(avail), .rd_word_o(rd_word)
  );

  cof_reader #(.DW(DW), .CW(CW), .EARLY(EARLY)) u_reader (
    .clk_i, .rst_ni, .rd_en_i, .avail_i(avail), .word_i(rd_word),
    .rd_idx_o(rd_idx), .free_o(free), .dat_o, .soc_o, .par_o,
    .vld_o(vld), .tail_o(tail)
  );

  assign cav_o = (vld && !(cfg_early_off_i && tail)) ^ cfg_cav_inv_i;

  assert_par_odd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld |-> (^{dat_o, par_o}) == 1'b1);
endmodule

// File: tb/cell_out_slave_bench.sv
`timescale 1ns/1ps
module cell_out_slave_bench;
  localparam int CW = 27;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, early = 1'b0, inv = 1'b0;
  logic [15:0] wr_data = '0;
  logic wr_full, wr_drop, soc, par, cav;
  logic [15:0] dat;

  always #4 clk = ~clk;

  cell_out_slave u_cell_out_slave (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_full_o(wr_full), .wr_drop_o(wr_drop), .rd_en_i(rd_en),
    .cfg_early_off_i(early), .cfg_cav_inv_i(inv),
    .dat_o(dat), .soc_o(soc), .par_o(par), .cav_o(cav)
  );

  int nchk = 0, nfail = 0;
  logic [15:0] mq[$];
  logic [15:0] wbuf[$];
  int mcells = 0, mridx = 0, mwidx = 0;
  bit mdrop = 0;
  bit e_vld, e_soc, e_drop, e_paused, e_starved;
  int e_idx;
  logic [15:0] e_dat;
  logic [15:0] seq = 16'h1000;

  task automatic chk(input bit ok, input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic void model(input bit we, input logic [15:0] wd, input bit re);
    int pre = mcells;
    e_paused  = !re && mridx != 0;
    e_starved = re && mridx == 0 && mcells == 0;
    e_vld = 0; e_soc = 0; e_drop = 0;
    if (re && (mridx != 0 || mcells > 0)) begin
      e_vld = 1; e_soc = (mridx == 0); e_idx = mridx; e_dat = mq[mridx];
      mridx++;
      if (mridx == CW) begin
        for (int i = 0; i < CW; i++) void'(mq.pop_front());
        mcells--; mridx = 0;
      end
    end
    if (we) begin
      if (mwidx == 0) mdrop = !(pre < DEPTH);
      if (mdrop) e_drop = 1; else wbuf.push_back(wd);
      mwidx++;
      if (mwidx == CW) begin
        mwidx = 0;
        if (!mdrop) begin
          for (int i = 0; i < CW; i++) mq.push_back(wbuf[i]);
          wbuf.delete();
          mcells++;
        end
      end
    end
  endfunction

  task automatic compare();
    bit ecav;
    string ct;
    ecav = (e_vld && !(early && e_idx >= CW - 4)) ^ inv;
    if (e_paused) ct = "R4";
    else if (e_starved) ct = "R2";
    else if (inv) ct = "R7";
    else if (early) ct = "R6";
    else ct = "R5";
    chk(cav === ecav, ct, {15'd0, cav}, {15'd0, ecav});
    chk(soc === e_soc, "R3", {15'd0, soc}, {15'd0, e_soc});
    if (e_vld) begin
      chk(dat === e_dat, "R10", dat, e_dat);
      chk(par === ~^e_dat, "R8", {15'd0, par}, {15'd0, ~^e_dat});
    end
    chk(wr_drop === e_drop, "R9", {15'd0, wr_drop}, {15'd0, e_drop});
    chk(wr_full === (mcells == DEPTH), "R9", {15'd0, wr_full}, {15'd0, mcells == DEPTH});
  endtask

  task automatic cyc(input bit we, input bit re);
    wr_en = we; rd_en = re;
    wr_data = seq;
    if (we) seq = seq + 16'h0107;
    @(posedge clk); #1;
    model(we, wr_data, re);
    @(negedge clk);
    compare();
  endtask

  task automatic write_cell(input bit re);
    for (int i = 0; i < CW; i++) cyc(1'b1, re);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (mcells > 0 || mridx != 0); i++) cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cav === 1'b0, "R1", {15'd0, cav}, 16'd0);
    chk(soc === 1'b0, "R1", {15'd0, soc}, 16'd0);
    chk(wr_full === 1'b0, "R1", {15'd0, wr_full}, 16'd0);
    chk(wr_drop === 1'b0, "R1", {15'd0, wr_drop}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: partial cell with read-enable high sends nothing
    for (int i = 0; i < CW - 1; i++) cyc(1'b1, 1'b1);
    chk(cav === 1'b0, "R2", {15'd0, cav}, 16'd0);
    cyc(1'b1, 1'b1);
    // R3/R4: first words, then a pause mid-cell, then resume
    repeat (5) cyc(1'b0, 1'b1);
    repeat (3) cyc(1'b0, 1'b0);
    chk(cav === 1'b0, "R4", {15'd0, cav}, 16'd0);
    drain();

    // R9: fill four cells, fifth is dropped, R10 order on drain
    for (int c = 0; c < DEPTH + 1; c++) write_cell(1'b0);
    chk(wr_full === 1'b1, "R9", {15'd0, wr_full}, 16'd1);
    drain();

    // R6 early deassertion
    early = 1'b1;
    write_cell(1'b0); write_cell(1'b0);
    drain();
    // R7 inversion, with and without early mode
    inv = 1'b1;
    write_cell(1'b0);
    drain();
    early = 1'b0;
    write_cell(1'b1);
    drain();
    inv = 1'b0;

    // random phases: whole cells with idle gaps, random read-enable
    for (int ph = 0; ph < 8; ph++) begin
      early = ph[0]; inv = ph[1];
      for (int n = 0; n < 12; n++) begin
        for (int w = 0; w < CW; w++) begin
          while ($urandom_range(0, 3) == 0) cyc(1'b0, $urandom_range(0, 9) < 7);
          cyc(1'b1, $urandom_range(0, 9) < ((ph >= 4) ? 3 : 7));
        end
      end
      drain();
    end

    summary();
    $finish;
  end
endmodule